// File: doc/BRIEF.md
# Register Rename Map with Free List

This block gives every instruction's result a fresh physical register so that later instructions no longer have to wait on earlier readers or writers of the same architectural register. A table holds the current physical register for each architectural register. A first-in first-out free list holds the physical registers that are not in use. For each decoded instruction with two sources and one destination, the block looks up the physical names of both sources in the current table. It hands out the physical register at the head of the free list as the destination. It points the destination's table entry at that new register, so instructions that come later read the new name.

The lookup outputs are combinational from the table as it stands before the instruction. An instruction whose source is also its destination therefore reads the previous mapping. Each rename also returns the physical register that the destination used to map to, so that retirement logic can free it later. A release port appends freed physical registers to the tail of the free list. When the list is empty, the block lowers its ready output and a presented instruction is held back.

Top module: `reg_rename`

## Requirements
- R1: After reset, architectural register i maps to physical register i. The free list holds physical registers ARCH_REGS to PHYS_REGS-1, and the lowest of them is handed out first.
- R2: `ren_psrc_a`, `ren_psrc_b` and `ren_pold` show, in the same cycle, the current mapping of `ren_src_a`, `ren_src_b` and `ren_dst`.
- R3: `ren_pdst` is the physical register at the head of the free list. A rename fires when `ren_valid` and `ren_ready` are both 1. After a rename, the table entry of the destination holds `ren_pdst`, and that register leaves the free list.
- R4: When a source equals the destination of the same instruction, the source gets the mapping from before that instruction's update.
- R5: `ren_ready` is 0 exactly when the free list is empty. A request made while `ren_ready` is 0 changes neither the table nor the free list.
- R6: A register presented on `rel_preg` with `rel_valid` = 1 goes to the tail of the free list. Registers are handed out in the order in which they entered the list.
- R7: A release made in a cycle when the list is empty does not raise `ren_ready` in that same cycle. The released register becomes available from the next cycle on.
- R8: A register handed out by a rename differs from the old mapping of its destination and from both of its source mappings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is presented for renaming |
| ren_ready | output | 1 | The free list is not empty, so a rename can fire |
| ren_src_a | input | 3 | First architectural source |
| ren_src_b | input | 3 | Second architectural source |
| ren_dst | input | 3 | Architectural destination |
| ren_psrc_a | output | 4 | Physical register for the first source |
| ren_psrc_b | output | 4 | Physical register for the second source |
| ren_pdst | output | 4 | Newly allocated physical destination |
| ren_pold | output | 4 | Previous physical mapping of the destination |
| rel_valid | input | 1 | A physical register is being freed |
| rel_preg | input | 4 | Physical register being freed |

## Verification
The bench aims at the following corner cases:
- An instruction that reads its own destination. A design that got this wrong would forward the new register and create a dependence on itself.
- The cycle right after a rename. A stale table here would give a later reader the old register and break a read-after-write dependence.
- Draining the free list to empty and then presenting a request. A faulty design would hand out a register it does not have, or would still change the table.
- A release that arrives while the list is empty. A design with a combinational bypass would raise ready early.
- Registers returned in a random order. A design that reused them out of order would allocate a register that is still live.

// File: rtl/rename_pkg.sv
package rename_pkg;
    parameter int unsigned ARCH_REGS_DEF = 8;
    parameter int unsigned PHYS_REGS_DEF = 16;

    function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table
    import rename_pkg::*;
#(
    parameter int unsigned ARCH_REGS = ARCH_REGS_DEF,
    parameter int unsigned PHYS_REGS = PHYS_REGS_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(ARCH_REGS)-1:0] rd_a_idx,
    input  logic [$clog2(ARCH_REGS)-1:0] rd_b_idx,
    input  logic [$clog2(ARCH_REGS)-1:0] rd_c_idx,
    output logic [$clog2(PHYS_REGS)-1:0] rd_a_tag,
    output logic [$clog2(PHYS_REGS)-1:0] rd_b_tag,
    output logic [$clog2(PHYS_REGS)-1:0] rd_c_tag,
    input  logic                         wr_en,
    input  logic [$clog2(ARCH_REGS)-1:0] wr_idx,
    input  logic [$clog2(PHYS_REGS)-1:0] wr_tag
);
    localparam int unsigned PW = $clog2(PHYS_REGS);

    typedef struct {
        logic [PW-1:0] ent [ARCH_REGS];
    } map_t;

    map_t st_d, st_q;

    function automatic map_t map_reset();
        map_t m;
        for (int i = 0; i < ARCH_REGS; i++) begin
            m.ent[i] = PW'(i);
        end
        return m;
    endfunction

    // reads see the table before this cycle's write
    assign rd_a_tag = st_q.ent[rd_a_idx];
    assign rd_b_tag = st_q.ent[rd_b_idx];
    assign rd_c_tag = st_q.ent[rd_c_idx];

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[wr_idx] = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= map_reset();
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rename_free_fifo.sv
module rename_free_fifo
    import rename_pkg::*;
#(
    parameter int unsigned ARCH_REGS = ARCH_REGS_DEF,
    parameter int unsigned PHYS_REGS = PHYS_REGS_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         pop,
    input  logic                         push,
    input  logic [$clog2(PHYS_REGS)-1:0] push_tag,
    output logic [$clog2(PHYS_REGS)-1:0] head_tag,
    output logic                         not_empty
);
    localparam int unsigned PW = $clog2(PHYS_REGS);
    localparam int unsigned CW = $clog2(PHYS_REGS + 1);
    localparam int unsigned INIT_FREE = PHYS_REGS - ARCH_REGS;

    typedef struct {
        logic [PW-1:0] slot [PHYS_REGS];
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] count;
    } fl_t;

    fl_t  st_d, st_q;
    logic do_pop, do_push;

    function automatic fl_t fl_reset();
        fl_t f;
        for (int i = 0; i < PHYS_REGS; i++) begin
            f.slot[i] = (i < INIT_FREE) ? PW'(i + ARCH_REGS) : '0;
        end
        f.head  = '0;
        f.tail  = PW'(INIT_FREE % PHYS_REGS);
        f.count = CW'(INIT_FREE);
        return f;
    endfunction

    assign not_empty = (st_q.count != '0);
    assign head_tag  = st_q.slot[st_q.head];

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && not_empty;
        do_push = push && ((st_q.count != CW'(PHYS_REGS)) || do_pop);
        if (do_pop) begin
            st_d.head = PW'(wrap_next(int'(st_q.head), PHYS_REGS));
        end
        if (do_push) begin
            st_d.slot[st_q.tail] = push_tag;
            st_d.tail = PW'(wrap_next(int'(st_q.tail), PHYS_REGS));
        end
        st_d.count = st_q.count + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= fl_reset();
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rename_pkg::*;
#(
    parameter int unsigned ARCH_REGS = ARCH_REGS_DEF,
    parameter int unsigned PHYS_REGS = PHYS_REGS_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ren_valid,
    output logic                         ren_ready,
    input  logic [$clog2(ARCH_REGS)-1:0] ren_src_a,
    input  logic [$clog2(ARCH_REGS)-1:0] ren_src_b,
    input  logic [$clog2(ARCH_REGS)-1:0] ren_dst,
    output logic [$clog2(PHYS_REGS)-1:0] ren_psrc_a,
    output logic [$clog2(PHYS_REGS)-1:0] ren_psrc_b,
    output logic [$clog2(PHYS_REGS)-1:0] ren_pdst,
    output logic [$clog2(PHYS_REGS)-1:0] ren_pold,
    input  logic                         rel_valid,
    input  logic [$clog2(PHYS_REGS)-1:0] rel_preg
);
    logic fire;

    assign fire = ren_valid && ren_ready;

    rename_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) map_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (ren_src_a),
        .rd_b_idx (ren_src_b),
        .rd_c_idx (ren_dst),
        .rd_a_tag (ren_psrc_a),
        .rd_b_tag (ren_psrc_b),
        .rd_c_tag (ren_pold),
        .wr_en    (fire),
        .wr_idx   (ren_dst),
        .wr_tag   (ren_pdst)
    );

    rename_free_fifo #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) free_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (fire),
        .push      (rel_valid),
        .push_tag  (rel_preg),
        .head_tag  (ren_pdst),
        .not_empty (ren_ready)
    );
endmodule

// File: rtl/rename_checker.sv
module rename_checker #(
    parameter int unsigned ARCH_REGS = 8,
    parameter int unsigned PHYS_REGS = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         ren_valid,
    input logic                         ren_ready,
    input logic [$clog2(ARCH_REGS)-1:0] ren_src_a,
    input logic [$clog2(ARCH_REGS)-1:0] ren_src_b,
    input logic [$clog2(ARCH_REGS)-1:0] ren_dst,
    input logic [$clog2(PHYS_REGS)-1:0] ren_psrc_a,
    input logic [$clog2(PHYS_REGS)-1:0] ren_psrc_b,
    input logic [$clog2(PHYS_REGS)-1:0] ren_pdst,
    input logic [$clog2(PHYS_REGS)-1:0] ren_pold,
    input logic                         rel_valid,
    input logic [$clog2(PHYS_REGS)-1:0] rel_preg
);
    localparam int unsigned CW = $clog2(PHYS_REGS + 1);

    logic          fire;
    logic [CW-1:0] occ_q;
    logic          armed_q;

    assign fire = ren_valid && ren_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q   <= CW'(PHYS_REGS - ARCH_REGS);
            armed_q <= 1'b0;
        end else begin
            occ_q   <= occ_q + CW'(rel_valid && (occ_q != CW'(PHYS_REGS) || fire)) - CW'(fire);
            armed_q <= 1'b1;
        end
    end

    assert_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ren_ready == (occ_q != '0));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !fire) |-> (occ_q < CW'(PHYS_REGS)));

    assert_fresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (ren_pdst != ren_pold && ren_pdst != ren_psrc_a && ren_pdst != ren_psrc_b));

    assert_self_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && ren_src_a == ren_dst) |-> (ren_psrc_a == ren_pold));

    assert_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(fire) && ren_src_a == $past(ren_dst)) |-> (ren_psrc_a == $past(ren_pdst)));

    assert_old_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(fire) && ren_dst == $past(ren_dst)) |-> (ren_pold == $past(ren_pdst)));
endmodule

bind reg_rename rename_checker #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) chk_i (.*);

// File: tb/reg_rename_tb.sv
module reg_rename_tb_top;
    localparam int NA = 8;
    localparam int NP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0;
    logic       ren_ready;
    logic [2:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic [3:0] ren_psrc_a, ren_psrc_b, ren_pdst, ren_pold;
    logic       rel_valid = 1'b0;
    logic [3:0] rel_preg = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int mmap [NA];
    int flist [NP];
    int fhead, fcnt;
    int pend [$];

    always #4 clk = ~clk;

    reg_rename dut_i (.*);

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_ready();
        return (fcnt != 0) ? 1 : 0;
    endfunction

    // one cycle: drive, check combinational outputs, then advance model and clock
    task automatic cyc(input string tag, input bit v, input int sa, input int sb, input int d,
                       input bit rv, input int rp);
        int e_pdst;
        ren_valid = v; ren_src_a = 3'(sa); ren_src_b = 3'(sb); ren_dst = 3'(d);
        rel_valid = rv; rel_preg = 4'(rp);
        #2;
        e_pdst = flist[fhead];
        chk(tag, "ready", int'(ren_ready), model_ready());
        chk(tag, "psrc_a", int'(ren_psrc_a), mmap[sa]);
        chk(tag, "psrc_b", int'(ren_psrc_b), mmap[sb]);
        chk(tag, "pold", int'(ren_pold), mmap[d]);
        if (fcnt != 0) begin
            chk(tag, "pdst", int'(ren_pdst), e_pdst);
            chk("R8", "pdst differs from pold", int'(ren_pdst != ren_pold), 1);
        end
        if (v && fcnt != 0) begin
            pend.push_back(mmap[d]);
            mmap[d] = e_pdst;
            fhead = (fhead + 1) % NP;
            fcnt--;
        end
        if (rv) begin
            flist[(fhead + fcnt) % NP] = rp;
            fcnt++;
        end
        @(posedge clk);
        #1;
        ren_valid = 1'b0;
        rel_valid = 1'b0;
    endtask

    task automatic cyc_rel(input string tag, input bit v, input int sa, input int sb, input int d,
                           input bit want_rel);
        int rp = 0;
        bit rv = 0;
        if (want_rel && pend.size() > 0) begin
            rp = pend.pop_front();
            rv = 1;
        end
        cyc(tag, v, sa, sb, d, rv, rp);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NA; i++) mmap[i] = i;
        for (int i = 0; i < NP; i++) flist[i] = (i < NP - NA) ? i + NA : 0;
        fhead = 0;
        fcnt = NP - NA;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: identity mapping and first free register after reset
        for (int i = 0; i < NA; i++) cyc("R1", 0, i, (i + 3) % NA, i, 0, 0);
        chk("R1", "first free", int'(ren_pdst), NA);

        // R4: add r3,r3 -> source keeps old name
        cyc("R4", 1, 3, 3, 3, 0, 0);
        // R3: later reader sees the new name
        cyc("R3", 0, 3, 3, 5, 0, 0);

        // R5: drain the list, then a blocked request must change nothing
        for (int i = 0; i < NP - NA - 1; i++) cyc("R5", 1, i % NA, 1, (i + 1) % NA, 0, 0);
        cyc("R5", 1, 0, 0, 0, 0, 0);
        cyc("R5", 1, 0, 1, 2, 0, 0);
        cyc("R5", 0, 0, 1, 2, 0, 0);

        // R7: release while empty, ready must stay low this cycle
        cyc_rel("R7", 1, 4, 5, 6, 1);
        cyc("R7", 1, 6, 4, 7, 0, 0);

        // R6: two releases in order, handed out in that order
        cyc_rel("R6", 0, 0, 0, 0, 1);
        cyc_rel("R6", 0, 0, 0, 0, 1);
        cyc("R6", 1, 1, 2, 1, 0, 0);
        cyc("R6", 1, 1, 2, 2, 0, 0);

        // R2: random traffic
        for (int k = 0; k < 2000; k++) begin
            cyc_rel("R2", ($urandom % 4) != 0, int'($urandom % NA), int'($urandom % NA),
                    int'($urandom % NA), ($urandom % 3) == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule